// File: doc/BRIEF.md
# Memory-Mapped Factorial Accelerator with Interrupt Status

This block is a register slave on a simple 32-bit word bus with byte offsets. It exposes a fixed identification word, a liveness word that reads back the bitwise inverse of the last value stored in it, and a sequential factorial engine. Software writes N to the factorial offset, and the engine works out N! one multiply per clock cycle. It keeps the low 32 bits of the product. Software reads the result from the same offset once the busy flag in the status word has dropped.

A single interrupt status word collects events. Engine completion sets bit 0 when the completion interrupt was enabled at start. Software can also OR any pattern into the word, and it clears bits by writing a mask to the acknowledge offset. A level interrupt output is high whenever the status word holds any set bit. Reads have no side effects. Read data is combinational from the offset presented.

Top module: `fact_mmio_accel`

## Requirements
- R1: Offset 0x00 reads the constant parameter ID_VALUE (default 0x00F4C7A1). Writes to it change nothing.
- R2: Offset 0x04 reads the bitwise inverse of the last value written there. After reset it reads 0xFFFFFFFF.
- R3: A write of N to offset 0x08 starts N!. When finished, 0x08 reads the low 32 bits of N!: 5 gives 120, 10 gives 3628800, and 13 gives 1932053504. After reset 0x08 reads 0.
- R4: An input of 0 or 1 yields a result of 1.
- R5: Status (offset 0x20) bit 0 is 1 for exactly max(N,1) clock cycles after the edge that accepts the factorial write, and 0 afterwards.
- R6: A write to 0x08 while status bit 0 is 1 is ignored. The running computation and its result are unaffected.
- R7: Status bit 7 is read/write, and all other status bits ignore writes. When bit 7 was 1 at the moment a computation started, its completion sets interrupt status (offset 0x24) bit 0. When it was 0, completion leaves the interrupt status unchanged.
- R8: A write to 0x60 ORs the written value into the interrupt status word.
- R9: A write to 0x64 clears the interrupt status bits that are 1 in the written value. 0xFFFFFFFF clears the whole word.
- R10: irq_o is 1 exactly when the interrupt status word is nonzero.
- R11: When engine completion and an acknowledge write land on the same clock edge, the completion bit stays set, while the other acknowledged bits clear.
- R12: Offsets that are not mapped read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| addr | input | 8 | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr (combinational) |
| irq_o | output | 1 | Level interrupt, high while any interrupt status bit is set |

## Verification
The hardest case to reach from the ports is an engine completion that falls on the same edge as an acknowledge write. Only one write can happen per cycle, and completion time depends on N. The bench uses the exact busy length promised by R5 to count cycles after the factorial write. It places an all-ones acknowledge on the completion edge, after a software-raised bit has been set. It then expects only the completion bit to survive. Busy-time writes to the factorial offset are issued mid-computation, and the final result is compared against the undisturbed value.

// File: rtl/fact_pkg.sv
package fact_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFS_ID     = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_LIVE   = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_FACT   = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_STAT   = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_IST    = 8'h24;
    localparam logic [ADDR_W-1:0] OFS_RAISE  = 8'h60;
    localparam logic [ADDR_W-1:0] OFS_ACK    = 8'h64;

    localparam int STAT_BUSY_BIT = 0;
    localparam int STAT_IEN_BIT  = 7;
    localparam int IST_DONE_BIT  = 0;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_ID,
        SEL_LIVE,
        SEL_FACT,
        SEL_STAT,
        SEL_IST,
        SEL_RAISE,
        SEL_ACK
    } reg_sel_e;

    typedef struct packed {
        logic                 we;
        reg_sel_e             sel;
        logic [DATA_W-1:0]    data;
    } bus_req_t;

    function automatic reg_sel_e decode_ofs(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        case (a)
            OFS_ID:    s = SEL_ID;
            OFS_LIVE:  s = SEL_LIVE;
            OFS_FACT:  s = SEL_FACT;
            OFS_STAT:  s = SEL_STAT;
            OFS_IST:   s = SEL_IST;
            OFS_RAISE: s = SEL_RAISE;
            OFS_ACK:   s = SEL_ACK;
            default:   s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/fact_engine.sv
module fact_engine #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] n_in,
    input  logic         ien_in,
    output logic         busy_o,
    output logic         done_o,
    output logic         done_irq_o,
    output logic [W-1:0] result_o
);

    logic [W-1:0] acc;
    logic [W-1:0] cnt;
    logic         busy;
    logic         ien_tag;
    logic         last;

    assign last = (cnt <= W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            acc     <= '0;
            cnt     <= '0;
            ien_tag <= 1'b0;
        end else if (start && !busy) begin
            busy    <= 1'b1;
            acc     <= W'(1);
            cnt     <= n_in;
            ien_tag <= ien_in;
        end else if (busy) begin
            if (last) begin
                busy <= 1'b0;
            end else begin
                acc <= acc * cnt;
                cnt <= cnt - W'(1);
            end
        end
    end

    assign busy_o     = busy;
    assign done_o     = busy && last;
    assign done_irq_o = busy && last && ien_tag;
    assign result_o   = acc;

    // R5: completion ends the busy window on the next edge
    a_r5_done_clears_busy: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !busy_o);
    // R5: busy never drops before the count is exhausted
    a_r5_busy_holds: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !done_o) |=> busy_o);
    // R6: busy only rises because of a start request
    a_r6_rise_needs_start: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(start));
    // R6: a start during a computation leaves the down-counter on its course
    a_r6_busy_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !done_o && start) |=> cnt == $past(cnt) - W'(1));
    // R3: a fresh computation begins from a product of one
    a_r3_start_seeds_one: assert property (@(posedge clk) disable iff (rst)
        (start && !busy_o) |=> (busy_o && result_o == W'(1)));

endmodule

// File: rtl/fact_irq_status.sv
module fact_irq_status #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         raise_we,
    input  logic         ack_we,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] hw_set,
    output logic [W-1:0] status_o,
    output logic         irq_o
);

    logic [W-1:0] ist;
    logic [W-1:0] clr_mask;
    logic [W-1:0] set_mask;

    always_comb begin
        clr_mask = ack_we   ? wdata : '0;
        set_mask = (raise_we ? wdata : '0) | hw_set;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ist <= '0;
        end else begin
            ist <= (ist & ~clr_mask) | set_mask;
        end
    end

    assign status_o = ist;
    assign irq_o    = |ist;

    // R8: raised bits are present after the write
    a_r8_raise_sets: assert property (@(posedge clk) disable iff (rst)
        raise_we |=> (status_o & $past(wdata)) == $past(wdata));
    // R9: acknowledged bits are gone unless hardware set them again
    a_r9_ack_clears: assert property (@(posedge clk) disable iff (rst)
        (ack_we && hw_set == '0) |=> (status_o & $past(wdata)) == '0);
    // R11: a hardware event wins over a simultaneous acknowledge
    a_r11_hw_beats_ack: assert property (@(posedge clk) disable iff (rst)
        (hw_set != '0) |=> (status_o & $past(hw_set)) == $past(hw_set));
    // R10: the line only rises after a set source was active
    a_r10_irq_rise_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_o) |-> $past(raise_we || hw_set != '0));

endmodule

// File: rtl/fact_mmio_accel.sv
module fact_mmio_accel
    import fact_pkg::*;
#(
    parameter logic [DATA_W-1:0] ID_VALUE = 32'h00F4C7A1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wdata,
    output logic [DATA_W-1:0]    rdata,
    output logic                 irq_o
);

    bus_req_t          req;
    logic [DATA_W-1:0] live_q;
    logic              ien_q;
    logic              eng_busy;
    logic              eng_done;
    logic              eng_done_irq;
    logic [DATA_W-1:0] eng_result;
    logic [DATA_W-1:0] ist;
    logic [DATA_W-1:0] hw_set;

    always_comb begin
        req.we   = wr_en;
        req.sel  = decode_ofs(addr);
        req.data = wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            live_q <= '0;
            ien_q  <= 1'b0;
        end else if (req.we) begin
            if (req.sel == SEL_LIVE) live_q <= req.data;
            if (req.sel == SEL_STAT) ien_q  <= req.data[STAT_IEN_BIT];
        end
    end

    fact_engine #(.W(DATA_W)) u_engine (
        .clk        (clk),
        .rst        (rst),
        .start      (req.we && req.sel == SEL_FACT),
        .n_in       (req.data),
        .ien_in     (ien_q),
        .busy_o     (eng_busy),
        .done_o     (eng_done),
        .done_irq_o (eng_done_irq),
        .result_o   (eng_result)
    );

    always_comb begin
        hw_set = '0;
        hw_set[IST_DONE_BIT] = eng_done_irq;
    end

    fact_irq_status #(.W(DATA_W)) u_irq (
        .clk      (clk),
        .rst      (rst),
        .raise_we (req.we && req.sel == SEL_RAISE),
        .ack_we   (req.we && req.sel == SEL_ACK),
        .wdata    (req.data),
        .hw_set   (hw_set),
        .status_o (ist),
        .irq_o    (irq_o)
    );

    always_comb begin
        rdata = '0;
        case (req.sel)
            SEL_ID:   rdata = ID_VALUE;
            SEL_LIVE: rdata = ~live_q;
            SEL_FACT: rdata = eng_result;
            SEL_STAT: begin
                rdata[STAT_BUSY_BIT] = eng_busy;
                rdata[STAT_IEN_BIT]  = ien_q;
            end
            SEL_IST:  rdata = ist;
            default:  rdata = '0;
        endcase
    end

    // R7: completion with the enable clear raises nothing
    a_r7_no_irq_when_disabled: assert property (@(posedge clk) disable iff (rst)
        (eng_done && !eng_done_irq && !(req.we && req.sel == SEL_RAISE) && ist == '0)
            |=> ist == '0);
    // R2: the liveness word always reads inverted storage
    a_r2_live_inverted: assert property (@(posedge clk) disable iff (rst)
        (req.we && req.sel == SEL_LIVE) |=> (live_q == $past(req.data)));

endmodule

// File: tb/fact_mmio_accel_bench.sv
`timescale 1ns/1ps
module fact_mmio_accel_bench;

    localparam logic [31:0] ID_EXP = 32'h00F4C7A1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    bit done_flag = 0;

    always #2 clk = ~clk;

    fact_mmio_accel u_fact_mmio_accel (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        addr = a;
        #0.5;
        v = rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        rd(8'h20, s);
        while (s[0]) rd(8'h20, s);
    endtask

    function automatic logic [31:0] fact_ref(input int n);
        logic [31:0] p = 32'd1;
        for (int i = 2; i <= n; i++) p = p * 32'(i);
        return p;
    endfunction

    task automatic t_reset();
        logic [31:0] v;
        rd(8'h04, v); chk("R2 reset live", v, 32'hFFFFFFFF);
        rd(8'h08, v); chk("R3 reset fact", v, 32'h0);
        rd(8'h20, v); chk("R5 reset status", v, 32'h0);
        rd(8'h24, v); chk("R9 reset ist", v, 32'h0);
        chk("R10 reset irq", {31'b0, irq_o}, 32'h0);
    endtask

    task automatic t_id();
        logic [31:0] v;
        rd(8'h00, v); chk("R1 id", v, ID_EXP);
        wr(8'h00, 32'h12345678);
        rd(8'h00, v); chk("R1 id write ignored", v, ID_EXP);
    endtask

    task automatic t_live();
        logic [31:0] v;
        wr(8'h04, 32'hDEADBEEF);
        rd(8'h04, v); chk("R2 live deadbeef", v, 32'h21524110);
        wr(8'h04, 32'h0);
        rd(8'h04, v); chk("R2 live zero", v, 32'hFFFFFFFF);
    endtask

    task automatic t_fact_values();
        logic [31:0] v;
        int ns[5] = '{5, 10, 13, 0, 1};
        foreach (ns[i]) begin
            wr(8'h08, 32'(ns[i]));
            wait_idle();
            rd(8'h08, v);
            if (ns[i] <= 1) chk("R4 fact of 0/1", v, 32'd1);
            else chk("R3 fact value", v, fact_ref(ns[i]));
        end
        chk("R3 ref 10!", fact_ref(10), 32'd3628800);
        chk("R3 ref 13!", fact_ref(13), 32'd1932053504);
    endtask

    task automatic t_busy_len();
        int ns[3] = '{0, 1, 4};
        foreach (ns[i]) begin
            int cnt = 0;
            int exp_len = (ns[i] < 1) ? 1 : ns[i];
            wr(8'h08, 32'(ns[i]));
            addr = 8'h20;
            #0.5;
            while (rdata[0] && cnt < 100) begin
                cnt++;
                @(negedge clk);
                #0.5;
            end
            chk("R5 busy length", 32'(cnt), 32'(exp_len));
        end
    endtask

    task automatic t_busy_ignore();
        logic [31:0] v;
        wr(8'h08, 32'd10);
        wr(8'h08, 32'd3);
        wr(8'h08, 32'd2);
        wait_idle();
        rd(8'h08, v); chk("R6 busy write ignored", v, 32'd3628800);
    endtask

    task automatic t_irq_enable();
        logic [31:0] v;
        wr(8'h20, 32'hFFFFFF7F);
        rd(8'h20, v); chk("R7 status bit7 only writable (clear)", v, 32'h0);
        wr(8'h08, 32'd3);
        wait_idle();
        rd(8'h24, v); chk("R7 no irq when disabled", v, 32'h0);
        wr(8'h20, 32'h80);
        rd(8'h20, v); chk("R7 status bit7 set", v, 32'h80);
        wr(8'h08, 32'd5);
        wr(8'h20, 32'h0);
        wait_idle();
        rd(8'h24, v); chk("R7 completion irq latched at start", v, 32'h1);
        chk("R10 irq high", {31'b0, irq_o}, 32'h1);
        rd(8'h08, v); chk("R3 fact 5", v, 32'd120);
        wr(8'h64, 32'h1);
        rd(8'h24, v); chk("R9 ack bit0", v, 32'h0);
        chk("R10 irq low", {31'b0, irq_o}, 32'h0);
    endtask

    task automatic t_raise_ack();
        logic [31:0] v;
        wr(8'h60, 32'hDEADBEEF);
        rd(8'h24, v); chk("R8 raise", v, 32'hDEADBEEF);
        wr(8'h60, 32'h00000110);
        rd(8'h24, v); chk("R8 raise or", v, 32'hDEADBFFF);
        wr(8'h64, 32'h0000FFFF);
        rd(8'h24, v); chk("R9 partial ack", v, 32'hDEAD0000);
        chk("R10 irq with upper bits", {31'b0, irq_o}, 32'h1);
        wr(8'h64, 32'hFFFFFFFF);
        rd(8'h24, v); chk("R9 full ack", v, 32'h0);
        chk("R10 irq cleared", {31'b0, irq_o}, 32'h0);
    endtask

    task automatic t_collision();
        logic [31:0] v;
        wr(8'h20, 32'h80);
        wr(8'h60, 32'h10);
        wr(8'h08, 32'd5);
        repeat (3) @(negedge clk);
        wr(8'h64, 32'hFFFFFFFF);
        rd(8'h24, v); chk("R11 done beats ack", v, 32'h1);
        chk("R11 irq still high", {31'b0, irq_o}, 32'h1);
        wr(8'h64, 32'hFFFFFFFF);
        wr(8'h20, 32'h0);
        rd(8'h24, v); chk("R9 clear after collision", v, 32'h0);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        wr(8'h40, 32'hFFFFFFFF);
        wr(8'hFC, 32'hA5A5A5A5);
        rd(8'h40, v); chk("R12 unmapped read", v, 32'h0);
        rd(8'h0C, v); chk("R12 unmapped read 0c", v, 32'h0);
        rd(8'h24, v); chk("R12 ist untouched", v, 32'h0);
        rd(8'h20, v); chk("R12 status untouched", v, 32'h0);
        rd(8'h04, v); chk("R12 live untouched", v, 32'hFFFFFFFF);
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_id();
        t_live();
        t_fact_values();
        t_busy_len();
        t_busy_ignore();
        t_irq_enable();
        t_raise_ack();
        t_collision();
        t_unmapped();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule